// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block governs the idle and run states of a two-channel sampling converter. It takes three inputs: an active-low power-down request for the whole chip, a two-bit sleep selection with one bit per channel, and a two-bit drive code for the common-mode buffer. From these it produces a sample-clock enable for each channel and a "ready" flag for each channel. A channel's ready flag rises only after that channel has counted its start-up delay. The block also produces a one-hot bias-level selection.

The analog settling is not modelled. It is represented only by counters that run on the sample clock. Waking from the deep power-down state takes a long count. Waking from the light sleep state takes a short count.

After a reset the block refuses to run either channel until it has seen one power-down request. Until then it raises a sticky reset-required flag.

Top module: `conv_mode_seq`

## Requirements
- R1: A low `pwrDownN` sampled at a clock edge overrides every other control input. From that edge both `chanClkEn` bits are 0 and both `chanReady` bits are 0.
- R2: With the block armed and `pwrDownN` high, bit 0 of `sleepSel` sets the state of channel 0 and bit 1 sets the state of channel 1. A bit value of 1 means run and 0 means sleep, so 00 is both asleep, 01 is channel 0 only, 10 is channel 1 only and 11 is both. A channel's `chanClkEn` equals its run state from the edge that samples the request.
- R3: A channel waking from power-down raises `chanReady` exactly `PD_WAKE_CYCLES` edges after the edge that first samples its run request, and not earlier.
- R4: A channel waking from sleep, with no power-down since it was last ready, raises `chanReady` exactly `SLEEP_WAKE_CYCLES` edges after the edge that samples its run request.
- R5: After reset, and until a low `pwrDownN` has been sampled, `resetReq` is 1 and both channels are held with `chanClkEn` = 0 and `chanReady` = 0 whatever `sleepSel` says. From the edge that samples the first power-down, `resetReq` is 0 and stays 0 until the next reset.
- R6: If a channel leaves the run state before its count completes, its ready flag stays low. A later run request counts again from zero for the full delay.
- R7: A channel leaving the run state drops both its `chanClkEn` and its `chanReady` at the edge that samples the change.
- R8: `biasSel` is a combinational one-hot decode of `biasCode`, with bit index equal to the code. Code 0 means buffer off, 1 means low drive (50 µA), 2 means medium drive (500 µA) and 3 means high drive (1 mA).
- R9: While `rstN` is low, `chanClkEn` and `chanReady` are 0 and `resetReq` is 1.
- R10: A channel that has been in power-down since it was last ready needs the long `PD_WAKE_CYCLES` delay, even if it passes through sleep on the way back to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDownN | input | 1 | Active-low chip power-down request |
| sleepSel | input | 2 | Per-channel run (1) or sleep (0) selection |
| biasCode | input | 2 | Common-mode buffer drive code |
| chanClkEn | output | 2 | Per-channel internal clock enable |
| chanReady | output | 2 | Per-channel start-up complete |
| biasSel | output | 4 | One-hot buffer drive selection |
| resetReq | output | 1 | Sticky flag: power-down still required after reset |

## Verification
The bench builds the block with `PD_WAKE_CYCLES` = 30 and `SLEEP_WAKE_CYCLES` = 5. With these values both exact ready edges, the long-delay path through sleep and the aborted counts are checked cycle by cycle within a few hundred cycles. The counts are kept distinct so that a wrong choice between the long and short delay shows up as a mismatch. The bench also applies every bias code and checks the refusal to run before the first power-down.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int CH_COUNT    = 2;
  localparam int BIAS_W      = 2;
  localparam int BIAS_LEVELS = 1 << BIAS_W;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_NAP = 2'd1,
    MODE_RUN = 2'd2
  } chanMode_t;

  typedef struct packed {
    logic [CH_COUNT-1:0] cntClear;
    logic [CH_COUNT-1:0] cntRun;
    logic [CH_COUNT-1:0] longWake;
  } seqStrobe_t;
endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrDownN,
  input  logic [CH_COUNT-1:0] sleepSel,
  input  logic [CH_COUNT-1:0] chanReady,
  output seqStrobe_t          strobe,
  output logic [CH_COUNT-1:0] chanClkEn,
  output logic                resetReq
);
  logic                armedQ;
  logic [CH_COUNT-1:0] clearVec;
  logic [CH_COUNT-1:0] runVec;
  logic [CH_COUNT-1:0] longVec;

  // Arming: the first sampled power-down unlocks run requests
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armedQ <= 1'b0;
    else if (!pwrDownN) armedQ <= 1'b1;
  end

  assign resetReq = ~armedQ;

  for (genvar g = 0; g < CH_COUNT; g++) begin : gChan
    chanMode_t reqMode;
    chanMode_t modeQ;
    logic      deepQ;

    always_comb begin
      if (!pwrDownN || !armedQ) reqMode = MODE_OFF;
      else if (sleepSel[g])     reqMode = MODE_RUN;
      else                      reqMode = MODE_NAP;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ <= MODE_OFF;
        deepQ <= 1'b1;
      end else begin
        modeQ <= reqMode;
        if (reqMode == MODE_OFF) deepQ <= 1'b1;
        else if (chanReady[g])   deepQ <= 1'b0;
      end
    end

    assign clearVec[g]  = (reqMode != modeQ);
    assign runVec[g]    = (reqMode == MODE_RUN) && (modeQ == MODE_RUN);
    assign longVec[g]   = deepQ;
    assign chanClkEn[g] = (modeQ == MODE_RUN);

    // R7
    drop_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chanClkEn[g]) |-> !chanReady[g]);
  end

  assign strobe = '{cntClear: clearVec, cntRun: runVec, longWake: longVec};

  // R1
  pd_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> (chanClkEn == '0) && (chanReady == '0));
  // R5
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resetReq |=> !resetReq);
  // R5
  hold_unarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (chanClkEn == '0) && (chanReady == '0));
endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int PD_WAKE_CYCLES    = 900,
  parameter int SLEEP_WAKE_CYCLES = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [BIAS_W-1:0]      biasCode,
  output logic [CH_COUNT-1:0]    chanReady,
  output logic [BIAS_LEVELS-1:0] biasSel
);
  localparam int CNT_W = $clog2(PD_WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(PD_WAKE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SLEEP_WAKE_CYCLES - 1);

  for (genvar g = 0; g < CH_COUNT; g++) begin : gCnt
    logic [CNT_W-1:0] cntQ;
    logic             readyQ;
    logic [CNT_W-1:0] lastCnt;

    assign lastCnt = strobe.longWake[g] ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ   <= '0;
        readyQ <= 1'b0;
      end else if (strobe.cntClear[g]) begin
        cntQ   <= '0;
        readyQ <= 1'b0;
      end else if (strobe.cntRun[g] && !readyQ) begin
        if (cntQ == lastCnt) readyQ <= 1'b1;
        else                 cntQ   <= cntQ + 1'b1;
      end
    end

    assign chanReady[g] = readyQ;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      cntQ <= LONG_LAST);
    // R3 R4
    ready_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(readyQ) |-> $past(strobe.cntRun[g]));
    // R6
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.cntClear[g] |=> !readyQ);
  end

  for (genvar lv = 0; lv < BIAS_LEVELS; lv++) begin : gBias
    assign biasSel[lv] = (biasCode == BIAS_W'(lv));
  end

  // R8
  bias_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(biasSel) == 1);
endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
  import pwrseq_pkg::*;
#(
  parameter int PD_WAKE_CYCLES    = 900,
  parameter int SLEEP_WAKE_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDownN,
  input  logic [1:0] sleepSel,
  input  logic [1:0] biasCode,
  output logic [1:0] chanClkEn,
  output logic [1:0] chanReady,
  output logic [3:0] biasSel,
  output logic       resetReq
);
  seqStrobe_t strobe;

  pwrseq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwrDownN (pwrDownN),
    .sleepSel (sleepSel),
    .chanReady(chanReady),
    .strobe   (strobe),
    .chanClkEn(chanClkEn),
    .resetReq (resetReq)
  );

  pwrseq_dp #(
    .PD_WAKE_CYCLES   (PD_WAKE_CYCLES),
    .SLEEP_WAKE_CYCLES(SLEEP_WAKE_CYCLES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .biasCode (biasCode),
    .chanReady(chanReady),
    .biasSel  (biasSel)
  );
endmodule

// File: tb/tb_conv_mode_seq.sv
module tb_conv_mode_seq;
  localparam int LONGW  = 30;
  localparam int SHORTW = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrDownN = 1'b1;
  logic [1:0] sleepSel = 2'b11;
  logic [1:0] biasCode = 2'b00;
  logic [1:0] chanClkEn;
  logic [1:0] chanReady;
  logic [3:0] biasSel;
  logic       resetReq;

  int checks = 0;
  int errors = 0;
  int cycNum = 0;
  bit finished = 0;

  typedef struct {
    int    cyc;
    int    kind;
    int    val;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cycNum <= cycNum + 1;

  conv_mode_seq #(.PD_WAKE_CYCLES(LONGW), .SLEEP_WAKE_CYCLES(SHORTW)) dut (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN), .sleepSel(sleepSel),
    .biasCode(biasCode), .chanClkEn(chanClkEn), .chanReady(chanReady),
    .biasSel(biasSel), .resetReq(resetReq)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kinds: 0 clock enables, 1 ready flags, 2 reset-required flag
  task automatic expectAt(input int cyc, input int kind, input int val, input string tag);
    expQ.push_back('{cyc, kind, val, tag});
  endtask

  task automatic apply(input logic pd, input logic [1:0] slp, output int k);
    @(negedge clk);
    pwrDownN = pd;
    sleepSel = slp;
    k = cycNum;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares every item due this cycle
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].cyc == cycNum) begin
        int act;
        case (expQ[i].kind)
          0:       act = int'(chanClkEn);
          1:       act = int'(chanReady);
          default: act = int'(resetReq);
        endcase
        checkVal(expQ[i].tag, act, expQ[i].val);
        expQ.delete(i);
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    int j;
    repeat (3) @(negedge clk);
    checkVal("R9 clkEn in reset", int'(chanClkEn), 0);
    checkVal("R9 ready in reset", int'(chanReady), 0);
    checkVal("R9 resetReq in reset", int'(resetReq), 1);
    rstN = 1'b1;

    // R8 bias decode, every code
    for (int c = 0; c < 4; c++) begin
      biasCode = 2'(c);
      #1;
      checkVal("R8 biasSel", int'(biasSel), 1 << c);
    end

    // R5 run request before any power-down is refused
    apply(1'b1, 2'b11, k);
    expectAt(k + 3, 0, 0, "R5 clkEn held before arming");
    expectAt(k + 3, 1, 0, "R5 ready held before arming");
    expectAt(k + 3, 2, 1, "R5 resetReq before arming");
    idle(5);

    // R1 power-down arms the block
    apply(1'b0, 2'b11, k);
    expectAt(k + 1, 2, 0, "R5 resetReq cleared");
    expectAt(k + 1, 0, 0, "R1 clkEn off in power-down");
    idle(3);

    // R3 long wake for both channels
    apply(1'b1, 2'b11, k);
    expectAt(k + 1, 0, 3, "R2 both run");
    expectAt(k + LONGW, 1, 0, "R3 ready not early");
    expectAt(k + LONGW + 1, 1, 3, "R3 ready at long count");
    idle(LONGW + 4);

    // R7 channel 1 to sleep (sleepSel 01)
    apply(1'b1, 2'b01, k);
    expectAt(k + 1, 0, 1, "R2 channel 0 only");
    expectAt(k + 1, 1, 1, "R7 channel 1 ready dropped");
    idle(3);

    // R4 short wake of channel 1
    apply(1'b1, 2'b11, k);
    expectAt(k + 1, 0, 3, "R2 both run again");
    expectAt(k + SHORTW, 1, 1, "R4 ready not early");
    expectAt(k + SHORTW + 1, 1, 3, "R4 ready at short count");
    idle(SHORTW + 4);

    // R6 abort channel 0 mid-count
    apply(1'b1, 2'b10, k);
    expectAt(k + 1, 0, 2, "R2 channel 1 only");
    expectAt(k + 1, 1, 2, "R7 channel 0 ready dropped");
    idle(2);
    apply(1'b1, 2'b11, j);
    idle(2);
    apply(1'b1, 2'b10, k);
    expectAt(k + 1, 1, 2, "R6 aborted count no ready");
    expectAt(k + SHORTW, 1, 2, "R6 still not ready");
    idle(SHORTW + 2);
    apply(1'b1, 2'b11, k);
    expectAt(k + SHORTW, 1, 2, "R6 restart not early");
    expectAt(k + SHORTW + 1, 1, 3, "R6 restart full count");
    idle(SHORTW + 4);

    // R10 power-down then sleep then run keeps the long delay
    apply(1'b0, 2'b11, k);
    expectAt(k + 1, 0, 0, "R1 clkEn off");
    expectAt(k + 1, 1, 0, "R1 ready off");
    idle(3);
    apply(1'b1, 2'b00, k);
    expectAt(k + 1, 0, 0, "R2 both asleep");
    idle(3);
    apply(1'b1, 2'b11, k);
    expectAt(k + SHORTW + 1, 1, 0, "R10 no short wake after power-down");
    expectAt(k + LONGW, 1, 0, "R10 not early");
    expectAt(k + LONGW + 1, 1, 3, "R10 long count");
    idle(LONGW + 4);

    // R6 power-down during a count, R1 override with sleep bus 11
    apply(1'b0, 2'b11, k);
    idle(2);
    apply(1'b1, 2'b11, k);
    idle(10);
    apply(1'b0, 2'b11, k);
    expectAt(k + 1, 1, 0, "R6 power-down aborts count");
    expectAt(k + 1, 0, 0, "R1 override clkEn");
    expectAt(k + 1, 2, 0, "R5 resetReq stays low");
    idle(4);

    while (expQ.size() != 0) begin
      checkVal({"R0 pending ", expQ[0].tag}, 0, 1);
      expQ.delete(0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule